// File: doc/BRIEF.md
# Watchdog and Alarm Countdown Timer

This block is a 24-bit down-counter that serves either as a repeating alarm or as a one-shot watchdog. A host reaches it through a small parallel register port with an address, a write strobe, a read strobe, write data and combinational read data. Every time step is derived from a single-cycle clock enable at 32.768 kHz. A free-running 15-bit prescaler divides that enable to produce a 4096 Hz step and a 1 Hz step.

In alarm mode the counter steps once per second. Each time it reaches zero it raises the alarm flag, loads the programmed value again and keeps running. In watchdog mode the counter steps 4096 times per second. When it reaches zero it raises the flag, stops and emits a 250 ms active-low pulse. A control bit steers that pulse to either the reset output or the interrupt output. Software keeps the watchdog from expiring by touching any counter byte, which reloads and restarts the count. A square-wave output runs at one of four rates derived from the same prescaler.

Top module: `wdt_alarm_timer`

## Requirements
- R1: After reset the control register reads 0x18, the status register reads 0x00, all three counter bytes read 0x00, and `rst_no` and `int_no` are both high.
- R2: Register map: addresses 0, 1 and 2 hold the counter bytes, least significant first. Address 3 is control, laid out as [0] count enable, [1] watchdog mode, [2] steer pulse to interrupt, [4:3] rate, [5] interrupt enable. Address 4 is status, with the alarm flag at [0]. While count enable is 0 the counter bytes are plain read/write storage and nothing counts, pulses or sets the flag.
- R3: With count enable and watchdog mode both 1, the counter steps every 8 enable ticks. When it reaches zero it sets the flag, stops, and starts a low pulse that lasts exactly 8192 enable ticks.
- R4: While counting is enabled, a read or a write of any counter byte reloads the count from the programmed value and restarts it.
- R5: When the steer bit is 0 the watchdog pulse appears on `rst_no` only. When the steer bit is 1 it appears on `int_no` only.
- R6: The alarm flag holds `int_no` low only while both interrupt enable and steer are 1. Otherwise a set flag leaves `int_no` high.
- R7: Clearing interrupt enable while a watchdog pulse is on `int_no` does not shorten that pulse.
- R8: With count enable 1 and watchdog mode 0, the counter steps every 32768 enable ticks. At zero it sets the flag and reloads, and it repeats this indefinitely. It never produces a pulse.
- R9: Writing a byte with bit 0 clear to the status register clears the alarm flag. A newly reached zero in the same cycle wins over the clear.
- R10: A programmed value of zero leaves the counter stopped, with no flag and no pulse.
- R11: The rate field selects `sqw_o` as follows. 00 gives a 1 Hz output (period 32768 ticks). 01 gives a period of 8 ticks. 10 gives a period of 4 ticks. 11 gives a copy of the enable delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 32.768 kHz single-cycle clock enable |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (counts as an access for reload) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| rst_no | output | 1 | Active-low watchdog reset pulse |
| int_no | output | 1 | Active-low interrupt and steered pulse |
| sqw_o | output | 1 | Square-wave output |

## Verification
The assertions assume that the enable input is a plain one-cycle strobe. They also assume that no host access lands on the same edge as a new pulse start while an earlier pulse is still running. The pulse-length check only requires that at least the full tick count elapses, so it still holds if a restart extends a pulse. The stimulus keeps the enable high every cycle, except during the rate-11 square-wave check, where it alternates. No counter byte is touched while a pulse is active, and the control register is rewritten during a pulse only to clear interrupt enable. Timeout instants are checked against a window of eight cycles, because the prescaler phase at the moment of enabling is not fixed.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    RATE_1HZ = 2'b00,
    RATE_4K  = 2'b01,
    RATE_8K  = 2'b10,
    RATE_32K = 2'b11
  } rate_e;

  typedef struct packed {
    logic  int_en;
    rate_e rate;
    logic  steer_int;
    logic  wd_mode;
    logic  cnt_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam ctrl_t CTRL_RST = '{int_en: 1'b0, rate: RATE_32K, steer_int: 1'b0,
                                 wd_mode: 1'b0, cnt_en: 1'b0};
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int unsigned PRESC_W    = 15,
  parameter int unsigned FAST_SHIFT = 3
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  rate_e rate_i,
  output logic  fast_tick_o,
  output logic  slow_tick_o,
  output logic  sqw_o
);
  logic [PRESC_W-1:0] presc_q;
  logic               sqw_d, sqw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     presc_q <= '0;
    else if (tick_i) presc_q <= presc_q + 1'b1;
  end

  assign fast_tick_o = tick_i && (&presc_q[FAST_SHIFT-1:0]);
  assign slow_tick_o = tick_i && (&presc_q);

  always_comb begin
    unique case (rate_i)
      RATE_1HZ: sqw_d = presc_q[PRESC_W-1];
      RATE_4K:  sqw_d = presc_q[FAST_SHIFT-1];
      RATE_8K:  sqw_d = presc_q[FAST_SHIFT-2];
      default:  sqw_d = tick_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sqw_q <= 1'b0;
    else         sqw_q <= sqw_d;
  end

  assign sqw_o = sqw_q;
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             wd_mode_i,
  input  logic             dec_tick_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_evt_o
);
  logic [CNT_W-1:0] count_q;
  logic             running_q;

  assign zero_evt_o = enable_i && running_q && dec_tick_i && !restart_i &&
                      (count_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= '0;
      running_q <= 1'b0;
    end else if (restart_i) begin
      count_q   <= reload_i;
      running_q <= |reload_i;
    end else if (!enable_i) begin
      running_q <= 1'b0;
    end else if (running_q && dec_tick_i) begin
      if (zero_evt_o) begin
        if (wd_mode_i) begin
          count_q   <= '0;
          running_q <= 1'b0;
        end else begin
          count_q   <= reload_i;
          running_q <= |reload_i;
        end
      end else begin
        count_q <= count_q - 1'b1;
      end
    end
  end

  assign count_o = count_q;
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int unsigned PULSE_TICKS = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  input  logic steer_int_i,
  output logic active_o,
  output logic to_int_o
);
  localparam int unsigned PW = $clog2(PULSE_TICKS);

  logic [PW-1:0] cnt_q;
  logic          active_q, to_int_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      to_int_q <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= PW'(PULSE_TICKS - 1);
      active_q <= 1'b1;
      to_int_q <= steer_int_i;
    end else if (active_q && tick_i) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;
  assign to_int_o = to_int_q;
endmodule

// File: rtl/wdt_alarm_timer.sv
module wdt_alarm_timer
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_BYTES   = 3,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PRESC_W     = 15,
  parameter int unsigned FAST_SHIFT  = 3,
  parameter int unsigned PULSE_TICKS = 8192
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_no,
  output logic              int_no,
  output logic              sqw_o
);
  localparam int unsigned CNT_W     = CNT_BYTES * DATA_W;
  localparam int unsigned CTRL_ADDR = CNT_BYTES;
  localparam int unsigned STAT_ADDR = CNT_BYTES + 1;

  ctrl_t              ctrl_q;
  logic               flag_q;
  logic [CNT_W-1:0]   reload_q, reload_d, count;
  logic [CNT_BYTES-1:0] byte_sel;
  logic               ctrl_wr, stat_wr, cnt_acc, en_rise, restart;
  logic               fast_tick, slow_tick, dec_tick, zero_evt;
  logic               pulse_active, pulse_to_int;

  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_sel
    assign byte_sel[b] = (addr_i == ADDR_W'(b));
  end

  assign ctrl_wr = we_i && (addr_i == ADDR_W'(CTRL_ADDR));
  assign stat_wr = we_i && (addr_i == ADDR_W'(STAT_ADDR));
  assign cnt_acc = (we_i || rd_i) && (|byte_sel);
  assign en_rise = ctrl_wr && wdata_i[0] && !ctrl_q.cnt_en;
  assign restart = en_rise || (cnt_acc && ctrl_q.cnt_en);

  always_comb begin
    reload_d = reload_q;
    for (int b = 0; b < CNT_BYTES; b++) begin
      if (we_i && byte_sel[b]) reload_d[b*DATA_W +: DATA_W] = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      ctrl_q   <= CTRL_RST;
    end else begin
      reload_q <= reload_d;
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end
  end

  // a new zero wins over a host clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      flag_q <= 1'b0;
    else if (zero_evt)                flag_q <= 1'b1;
    else if (stat_wr && !wdata_i[0])  flag_q <= 1'b0;
  end

  wdt_prescaler #(
    .PRESC_W   (PRESC_W),
    .FAST_SHIFT(FAST_SHIFT)
  ) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .rate_i     (ctrl_q.rate),
    .fast_tick_o(fast_tick),
    .slow_tick_o(slow_tick),
    .sqw_o      (sqw_o)
  );

  assign dec_tick = ctrl_q.wd_mode ? fast_tick : slow_tick;

  wdt_countdown #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (ctrl_q.cnt_en),
    .wd_mode_i (ctrl_q.wd_mode),
    .dec_tick_i(dec_tick),
    .restart_i (restart),
    .reload_i  (reload_d),
    .count_o   (count),
    .zero_evt_o(zero_evt)
  );

  wdt_pulse_gen #(
    .PULSE_TICKS(PULSE_TICKS)
  ) u_pulse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .start_i    (zero_evt && ctrl_q.wd_mode),
    .steer_int_i(ctrl_q.steer_int),
    .active_o   (pulse_active),
    .to_int_o   (pulse_to_int)
  );

  assign rst_no = !(pulse_active && !pulse_to_int);
  assign int_no = !((pulse_active && pulse_to_int) ||
                    (flag_q && ctrl_q.int_en && ctrl_q.steer_int));

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < CNT_BYTES; b++) begin
      if (byte_sel[b])
        rdata_o = ctrl_q.cnt_en ? count[b*DATA_W +: DATA_W] : reload_q[b*DATA_W +: DATA_W];
    end
    if (addr_i == ADDR_W'(CTRL_ADDR)) rdata_o = DATA_W'(ctrl_q);
    if (addr_i == ADDR_W'(STAT_ADDR)) rdata_o = DATA_W'(flag_q);
  end
endmodule

// File: rtl/wdt_alarm_timer_checker.sv
module wdt_alarm_timer_checker #(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned PULSE_TICKS = 8192,
  parameter int unsigned STAT_ADDR   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [7:0]        wdata_i,
  input logic              rst_no,
  input logic              int_no,
  input logic              cnt_en,
  input logic              wd_mode,
  input logic              steer_int,
  input logic              int_en,
  input logic              flag_q,
  input logic              zero_evt,
  input logic [CNT_W-1:0]  reload_q,
  input logic              pulse_active,
  input logic              pulse_to_int
);
  int unsigned act_ticks;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            act_ticks <= 0;
    else if (!pulse_active) act_ticks <= 0;
    else if (tick_i)        act_ticks <= act_ticks + 1;
  end

  AST_NO_EVT_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_evt |-> cnt_en); // R2
  AST_FLAG_WITH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_active) |-> flag_q); // R3
  AST_RST_STEERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_no) |-> $past(wd_mode) && !$past(steer_int)); // R5
  AST_ALARM_INT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_no && !pulse_active) |-> (int_en && steer_int && flag_q)); // R6
  AST_PULSE_FULL_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_active) |-> (act_ticks >= PULSE_TICKS)); // R7
  AST_NO_PULSE_ALARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_active) |-> $past(wd_mode)); // R8
  AST_FLAG_CLEAR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(we_i && (addr_i == ADDR_W'(STAT_ADDR)) && !wdata_i[0])); // R9
  AST_ZERO_RELOAD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_evt |-> (reload_q != '0)); // R10
endmodule

bind wdt_alarm_timer wdt_alarm_timer_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .addr_i      (addr_i),
  .we_i        (we_i),
  .wdata_i     (wdata_i),
  .rst_no      (rst_no),
  .int_no      (int_no),
  .cnt_en      (ctrl_q.cnt_en),
  .wd_mode     (ctrl_q.wd_mode),
  .steer_int   (ctrl_q.steer_int),
  .int_en      (ctrl_q.int_en),
  .flag_q      (flag_q),
  .zero_evt    (zero_evt),
  .reload_q    (reload_q),
  .pulse_active(pulse_active),
  .pulse_to_int(pulse_to_int)
);

// File: tb/wdt_alarm_timer_bench.sv
module wdt_alarm_timer_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic [2:0] addr_i = '0;
  logic       we_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       rst_no, int_no, sqw_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  wdt_alarm_timer u_wdt_alarm_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .addr_i (addr_i),
    .we_i   (we_i),
    .rd_i   (rd_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .rst_no (rst_no),
    .int_no (int_no),
    .sqw_o  (sqw_o)
  );

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles == 200000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 200000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic setup(input logic [23:0] v);
    wr(3'd3, 8'h18);
    wr(3'd0, v[7:0]);
    wr(3'd1, v[15:8]);
    wr(3'd2, v[23:16]);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk(rst_no === 1'b1, "R1 rst_no after reset", int'(rst_no), 1);
    chk(int_no === 1'b1, "R1 int_no after reset", int'(int_no), 1);
    rd(3'd3, d); chk(d == 8'h18, "R1 control default", int'(d), 8'h18);
    rd(3'd4, d); chk(d == 8'h00, "R1 status default", int'(d), 0);
    rd(3'd2, d); chk(d == 8'h00, "R1 counter byte default", int'(d), 0);
  endtask

  task automatic t_storage();
    logic [7:0] d;
    int bad = 0;
    wr(3'd0, 8'h12); wr(3'd1, 8'h34); wr(3'd2, 8'h01);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (!rst_no || !int_no) bad++;
    end
    chk(bad == 0, "R2 no pulse while disabled", bad, 0);
    rd(3'd0, d); chk(d == 8'h12, "R2 byte0 storage", int'(d), 8'h12);
    rd(3'd1, d); chk(d == 8'h34, "R2 byte1 storage", int'(d), 8'h34);
    rd(3'd2, d); chk(d == 8'h01, "R2 byte2 storage", int'(d), 8'h01);
    rd(3'd4, d); chk(d == 8'h00, "R2 flag untouched while disabled", int'(d), 0);
  endtask

  task automatic t_sqw();
    int last, per1, per2, n;
    logic prev;
    wr(3'd3, 8'h08);
    last = -1; per1 = 0; per2 = 0; n = 0; prev = sqw_o;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (sqw_o && !prev) begin
        if (last >= 0) begin per2 = per1; per1 = i - last; n++; end
        last = i;
      end
      prev = sqw_o;
    end
    chk(n >= 2 && per1 == 8 && per2 == 8, "R11 rate 01 period", per1, 8);
    wr(3'd3, 8'h10);
    last = -1; per1 = 0; per2 = 0; n = 0; prev = sqw_o;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (sqw_o && !prev) begin
        if (last >= 0) begin per2 = per1; per1 = i - last; n++; end
        last = i;
      end
      prev = sqw_o;
    end
    chk(n >= 2 && per1 == 4 && per2 == 4, "R11 rate 10 period", per1, 4);
    wr(3'd3, 8'h18);
    last = -1; per1 = 0; n = 0; prev = sqw_o;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      tick_i = ~tick_i;
      if (sqw_o && !prev) begin
        if (last >= 0) begin per1 = i - last; n++; end
        last = i;
      end
      prev = sqw_o;
    end
    tick_i = 1'b1;
    chk(n >= 2 && per1 == 2, "R11 rate 11 follows enable", per1, 2);
  endtask

  task automatic t_wd_rst();
    logic [7:0] d;
    int n = 0, low = 0, il = 0;
    setup(24'd4);
    wr(3'd3, 8'h1B);
    while (rst_no && n < 100) begin @(negedge clk_i); n++; end
    chk(n >= 20 && n <= 40, "R3 watchdog timeout in 4 steps of 8 ticks", n, 32);
    while (!rst_no && low < 9000) begin
      if (!int_no) il++;
      @(negedge clk_i); low++;
    end
    chk(low == 8192, "R3 pulse length", low, 8192);
    chk(il == 0, "R5 steer 0 keeps int_no high", il, 0);
    rd(3'd4, d); chk(d == 8'h01, "R3 flag set at zero", int'(d), 1);
  endtask

  task automatic t_kick();
    logic [7:0] d;
    int bad = 0, n = 0, low = 0;
    setup(24'd4);
    wr(3'd3, 8'h1B);
    for (int k = 0; k < 20; k++) begin
      if (k % 2 == 0) rd(3'd0, d);
      else            wr(3'd1, 8'h00);
      for (int i = 0; i < 14; i++) begin
        @(negedge clk_i);
        if (!rst_no) bad++;
      end
    end
    chk(bad == 0, "R4 accesses keep watchdog from expiring", bad, 0);
    while (rst_no && n < 100) begin @(negedge clk_i); n++; end
    chk(n <= 40, "R4 expiry after kicks stop", n, 32);
    while (!rst_no && low < 9000) begin @(negedge clk_i); low++; end
  endtask

  task automatic t_steer_int();
    logic [7:0] d;
    int n = 0, low = 0, rl = 0;
    setup(24'd3);
    wr(3'd3, 8'h3F);
    while (int_no && n < 100) begin @(negedge clk_i); n++; end
    chk(n >= 12 && n <= 30, "R5 pulse on int_no", n, 24);
    for (int i = 0; i < 100; i++) begin
      if (!rst_no) rl++;
      @(negedge clk_i); low++;
    end
    wr(3'd3, 8'h1F);
    low += 2;
    while (!int_no && low < 9000) begin
      if (!rst_no) rl++;
      @(negedge clk_i); low++;
    end
    chk(low == 8192, "R7 pulse not cut by clearing interrupt enable", low, 8192);
    chk(rl == 0, "R5 steer 1 keeps rst_no high", rl, 0);
    rd(3'd4, d); chk(d == 8'h01, "R6 flag set", int'(d), 1);
    chk(int_no === 1'b1, "R6 flag ignored with interrupt enable 0", int'(int_no), 1);
  endtask

  task automatic t_zero();
    logic [7:0] d;
    int bad = 0;
    setup(24'd0);
    wr(3'd3, 8'h3F);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      if (!rst_no || !int_no) bad++;
    end
    chk(bad == 0, "R10 zero reload gives no pulse", bad, 0);
    rd(3'd4, d); chk(d == 8'h00, "R10 zero reload gives no flag", int'(d), 0);
  endtask

  task automatic t_alarm();
    logic [7:0] d;
    int n = 0, rl = 0, il = 0;
    bit seen = 1'b0;
    setup(24'd1);
    wr(3'd3, 8'h3D);
    while (int_no && n < 33000) begin
      if (!rst_no) rl++;
      @(negedge clk_i); n++;
    end
    chk(n < 32800, "R8 alarm zero within one second", n, 32768);
    rd(3'd4, d); chk(d == 8'h01, "R8 alarm sets flag", int'(d), 1);
    wr(3'd4, 8'h00);
    chk(int_no === 1'b1, "R9 clearing flag releases int_no", int'(int_no), 1);
    rd(3'd4, d); chk(d == 8'h00, "R9 flag reads cleared", int'(d), 0);
    wr(3'd3, 8'h1D);
    n = 0;
    while (!seen && n < 33000) begin
      rd(3'd4, d);
      if (d[0]) seen = 1'b1;
      if (!int_no) il++;
      if (!rst_no) rl++;
      n++;
    end
    chk(seen, "R8 alarm repeats after reload", int'(seen), 1);
    chk(il == 0, "R6 flag ignored with interrupt enable 0", il, 0);
    chk(rl == 0, "R8 alarm mode never pulses rst_no", rl, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_storage();
    t_sqw();
    t_wd_rst();
    t_kick();
    t_steer_int();
    t_zero();
    t_alarm();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule